// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that sits on a 16-bit register bus. Software sets the clock rate, the sampling edge and the interrupt signalling in two setup registers, and loads a transmit word as two 16-bit halves. A write to the control register then starts one command. A write command only transmits. A read command transmits the same word and also captures the returned bits. The word length can be set from 4 to 32 bits.

Each command has its own completion flag in the status register and its own interrupt line. Received bits are returned as two 16-bit halves. The control register also carries a separate chip-select command. Software uses it to assert or release either of two chip-select lines directly.

The serial clock idles low. Its half-period is a power of two of the system clock. The divider only advances while the clock-enable bit is set.

Top module: `spi_reg_master`

## Requirements
- R1: Registers are addressed by a 3-bit word index. The mapping is: 0 setup A, 1 setup B, 2 control, 3 status, 4 transmit low, 5 transmit high, 6 receive low, 7 receive high. Setup A holds bit 0 clock enable, bits 3:1 divisor, bit 4 write-interrupt enable and bit 5 read-interrupt enable. Setup B holds bit 0 sample edge (1 = rising, 0 = falling), bit 5 interrupt polarity (1 = active high) and bit 10 edge signalling (1 = one-cycle pulse). Unimplemented bits read as 0.
- R2: After reset, every register reads 0, `cs_n_o` is 2'b11, `sclk_o` is 0 and both interrupt lines are 1.
- R3: The serial clock half-period is 2^divisor system clocks. A command of N bits whose control write is taken at clock edge E0 sets its status flag so that the flag reads 1 after edge E0+2·N·2^divisor+1, and still reads 0 one edge earlier.
- R4: Control bits 6:2 hold the word length minus one. Values below 3 are treated as 3, so a command gives exactly max(field+1,4) rising edges on `sclk_o`.
- R5: Data shifts out MSB first from {transmit high, transmit low}, using the top N bits. With sample edge 1, `mosi_o` changes on falling `sclk_o` and is valid at the rising edge. With sample edge 0, it changes on rising and is valid at the falling edge.
- R6: A read command, started by control bit 0, samples `miso_i` on the selected edge. When it completes, receive {high, low} holds the N bits right-justified. A write command, started by control bit 1, leaves the receive registers unchanged. If both bits are set, the command is a read.
- R7: While setup A bit 0 is 0, a started command makes no `sclk_o` edge and does not complete. It resumes once the bit is set.
- R8: A command written while another is in progress is ignored. Only the first command's bit count appears on `sclk_o`, and the ignored command's flag stays clear.
- R9: Status bit 0 is the read-complete flag and bit 1 is the write-complete flag. Each flag is set on completion of its command and cleared when that command starts. A status write clears every flag whose written bit is 0.
- R10: A control write with bit 10 set is a chip-select command and starts no transfer. Bits 8:7 select the lines (bit 7 for line 0, bit 8 for line 1). Bit 0 equal to 0 asserts the selected lines (`cs_n_o` low); bit 0 equal to 1 releases them. So 0x05FC asserts both lines and 0x05FD releases both.
- R11: In level mode, `irq_o[0]` follows (read flag AND read enable) and `irq_o[1]` follows (write flag AND write enable), with one clock of latency and inverted when the polarity is 0.
- R12: In edge mode, each flag's rise with its enable set produces exactly one clock-wide active pulse on the matching interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Chip selects, active low |
| irq_o | output | 2 | Interrupts: bit 0 read complete, bit 1 write complete |

## Verification
A completion flag is due exactly 2·N·2^divisor+1 clock edges after the edge that takes the control write. The bench counts those edges and reads status one edge before and at that point. Interrupt lines follow their flag one edge later, so they are read a few cycles after completion. Edge-mode pulses are counted as high cycles over the whole command. Serial bits are sampled by a bench monitor on the selected `sclk_o` edge, and `miso_i` is looped back from `mosi_o` so read data has a known value. All register reads and port checks happen at the falling system-clock edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LEN_W   = $clog2(WORD_W);
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned MIN_LEN = 4;

  localparam logic [2:0] IDX_CFG_A = 3'd0;
  localparam logic [2:0] IDX_CFG_B = 3'd1;
  localparam logic [2:0] IDX_CTRL  = 3'd2;
  localparam logic [2:0] IDX_STAT  = 3'd3;
  localparam logic [2:0] IDX_TX_LO = 3'd4;
  localparam logic [2:0] IDX_TX_HI = 3'd5;
  localparam logic [2:0] IDX_RX_LO = 3'd6;
  localparam logic [2:0] IDX_RX_HI = 3'd7;

  localparam int CFG_CLKEN = 0;
  localparam int CFG_DIV   = 1;
  localparam int CFG_WIE   = 4;
  localparam int CFG_RIE   = 5;
  localparam int CFG_A_W   = 6;

  localparam int MODE_EDGE = 0;
  localparam int MODE_POL  = 5;
  localparam int MODE_TRIG = 10;

  localparam int CTL_RD    = 0;
  localparam int CTL_WR    = 1;
  localparam int CTL_LEN   = 2;
  localparam int CTL_CS    = 7;
  localparam int CTL_CSCMD = 10;

  localparam int ST_RD = 0;
  localparam int ST_WR = 1;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_reg_pkg::*;
#(
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  localparam int unsigned CNT_W = (1 << DW) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // top divisor wraps to zero before the decrement, giving all ones
  assign lim    = (CNT_W'(1) << div_i) - CNT_W'(1);
  assign tick_o = busy_i && en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!busy_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_reg_pkg::*;
#(
  parameter int unsigned WW = WORD_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_rd_i,
  input  logic [LW-1:0] len_i,
  input  logic [WW-1:0] tx_i,
  input  logic          rise_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output logic          busy_o,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          done_o,
  output logic          done_rd_o,
  output logic [WW-1:0] rx_o
);
  localparam logic [LW-1:0] LEN_MIN = LW'(MIN_LEN - 1);

  logic          busy_q, sclk_q, mosi_q, done_q, op_q, rise_q;
  logic [LW-1:0] len_q, bit_cnt_q, len_c;
  logic [WW-1:0] sh_q, rx_q;
  logic          last;

  assign len_c = (len_i < LEN_MIN) ? LEN_MIN : len_i;
  assign last  = (bit_cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
      done_q    <= 1'b0;
      op_q      <= 1'b0;
      rise_q    <= 1'b0;
      len_q     <= '0;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      rx_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q    <= 1'b1;
        sclk_q    <= 1'b0;
        op_q      <= op_rd_i;
        rise_q    <= rise_i;
        len_q     <= len_c;
        bit_cnt_q <= '0;
        rx_q      <= '0;
        if (rise_i) begin
          mosi_q <= tx_i[WW-1];
          sh_q   <= {tx_i[WW-2:0], 1'b0};
        end else begin
          sh_q   <= tx_i;
        end
      end else if (busy_q && tick_i) begin
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          if (rise_q) rx_q <= {rx_q[WW-2:0], miso_i};
          else begin
            mosi_q <= sh_q[WW-1];
            sh_q   <= {sh_q[WW-2:0], 1'b0};
          end
        end else begin
          if (!rise_q) rx_q <= {rx_q[WW-2:0], miso_i};
          else if (!last) begin
            mosi_q <= sh_q[WW-1];
            sh_q   <= {sh_q[WW-2:0], 1'b0};
          end
          bit_cnt_q <= bit_cnt_q + LW'(1);
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = mosi_q;
  assign done_o    = done_q;
  assign done_rd_o = op_q;
  assign rx_o      = rx_q;

  // R5
  sclk_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  // R3
  sclk_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_q) |-> $past(tick_i && busy_q));
  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(len_q) && $stable(op_q) && $stable(rise_q)));
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic en_i,
  input  logic pos_i,
  input  logic edge_i,
  output logic irq_o
);
  logic flag_d_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_d_q <= 1'b0;
      act_q    <= 1'b0;
    end else begin
      flag_d_q <= flag_i;
      act_q    <= en_i && (edge_i ? (flag_i && !flag_d_q) : flag_i);
    end
  end

  assign irq_o = pos_i ? act_q : ~act_q;

  // R12
  edge_pulse_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && edge_i) |=> (!act_q || !edge_i));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int unsigned NUM_CS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              sclk_o,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic [1:0]        irq_o
);
  logic [CFG_A_W-1:0] cfg_a_q;
  logic               rise_q, pol_pos_q, trig_edge_q;
  logic [LEN_W-1:0]   len_q;
  logic [NUM_CS-1:0]  cs_act_q;
  logic [REG_W-1:0]   tx_lo_q, tx_hi_q;
  logic [WORD_W-1:0]  rx_q, eng_rx;
  logic [1:0]         flag_q;

  logic wr_cfg_a, wr_cfg_b, wr_ctrl, wr_stat, wr_tx_lo, wr_tx_hi;
  logic cs_cmd, start_req, accept, busy, tick, done, done_rd;
  logic [1:0] start_ch, done_ch, irq_en;
  logic [NUM_CS-1:0] cs_mask;

  assign wr_cfg_a  = we_i && (addr_i == IDX_CFG_A);
  assign wr_cfg_b  = we_i && (addr_i == IDX_CFG_B);
  assign wr_ctrl   = we_i && (addr_i == IDX_CTRL);
  assign wr_stat   = we_i && (addr_i == IDX_STAT);
  assign wr_tx_lo  = we_i && (addr_i == IDX_TX_LO);
  assign wr_tx_hi  = we_i && (addr_i == IDX_TX_HI);

  assign cs_cmd    = wdata_i[CTL_CSCMD];
  assign cs_mask   = wdata_i[CTL_CS +: NUM_CS];
  assign start_req = wr_ctrl && !cs_cmd && (wdata_i[CTL_RD] || wdata_i[CTL_WR]);
  assign accept    = start_req && !busy;

  assign start_ch  = accept ? (wdata_i[CTL_RD] ? 2'b01 : 2'b10) : 2'b00;
  assign done_ch   = done ? (done_rd ? 2'b01 : 2'b10) : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q     <= '0;
      rise_q      <= 1'b0;
      pol_pos_q   <= 1'b0;
      trig_edge_q <= 1'b0;
      len_q       <= '0;
      cs_act_q    <= '0;
      tx_lo_q     <= '0;
      tx_hi_q     <= '0;
      rx_q        <= '0;
      flag_q      <= '0;
    end else begin
      if (wr_cfg_a) cfg_a_q <= wdata_i[CFG_A_W-1:0];
      if (wr_cfg_b) begin
        rise_q      <= wdata_i[MODE_EDGE];
        pol_pos_q   <= wdata_i[MODE_POL];
        trig_edge_q <= wdata_i[MODE_TRIG];
      end
      if (wr_tx_lo) tx_lo_q <= wdata_i;
      if (wr_tx_hi) tx_hi_q <= wdata_i;
      if (accept) len_q <= wdata_i[CTL_LEN +: LEN_W];
      if (wr_ctrl && cs_cmd) begin
        if (wdata_i[CTL_RD]) cs_act_q <= cs_act_q & ~cs_mask;
        else                 cs_act_q <= cs_act_q | cs_mask;
      end
      if (done && done_rd) rx_q <= eng_rx;
      // start clears, completion sets, status write clears on zero bits
      for (int b = 0; b < 2; b++) begin
        if (start_ch[b])     flag_q[b] <= 1'b0;
        else if (done_ch[b]) flag_q[b] <= 1'b1;
        else if (wr_stat)    flag_q[b] <= flag_q[b] & wdata_i[b];
      end
    end
  end

  spi_clk_div #(.DW(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .en_i   (cfg_a_q[CFG_CLKEN]),
    .div_i  (cfg_a_q[CFG_DIV +: DIV_W]),
    .tick_o (tick)
  );

  spi_shift_engine #(.WW(WORD_W), .LW(LEN_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_req),
    .op_rd_i   (wdata_i[CTL_RD]),
    .len_i     (wdata_i[CTL_LEN +: LEN_W]),
    .tx_i      ({tx_hi_q, tx_lo_q}),
    .rise_i    (rise_q),
    .tick_i    (tick),
    .miso_i    (miso_i),
    .busy_o    (busy),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .done_o    (done),
    .done_rd_o (done_rd),
    .rx_o      (eng_rx)
  );

  assign irq_en = {cfg_a_q[CFG_WIE], cfg_a_q[CFG_RIE]};

  for (genvar g = 0; g < 2; g++) begin : g_irq
    spi_irq_gen u_irq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flag_i (flag_q[g]),
      .en_i   (irq_en[g]),
      .pos_i  (pol_pos_q),
      .edge_i (trig_edge_q),
      .irq_o  (irq_o[g])
    );
  end

  assign cs_n_o = ~cs_act_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      IDX_CFG_A: rdata_o[CFG_A_W-1:0] = cfg_a_q;
      IDX_CFG_B: begin
        rdata_o[MODE_EDGE] = rise_q;
        rdata_o[MODE_POL]  = pol_pos_q;
        rdata_o[MODE_TRIG] = trig_edge_q;
      end
      IDX_CTRL: begin
        rdata_o[CTL_LEN +: LEN_W] = len_q;
        rdata_o[CTL_CS +: NUM_CS] = cs_act_q;
      end
      IDX_STAT:  rdata_o[1:0] = flag_q;
      IDX_TX_LO: rdata_o = tx_lo_q;
      IDX_TX_HI: rdata_o = tx_hi_q;
      IDX_RX_LO: rdata_o = rx_q[REG_W-1:0];
      IDX_RX_HI: rdata_o = rx_q[WORD_W-1:REG_W];
      default:   rdata_o = '0;
    endcase
  end

  // R9
  flag_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[ST_WR]) |-> $past(done && !done_rd));
  // R10
  cs_only_on_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cs_n_o) |-> $past(wr_ctrl && cs_cmd));
  // R7
  clk_en_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cfg_a_q[CFG_CLKEN]) |-> $stable(sclk_o));
endmodule

// File: tb/spi_reg_master_bench.sv
module spi_reg_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sclk, mosi, miso;
  logic [1:0]  cs_n, irq;
  logic        loop_en = 1'b1;

  int checks = 0;
  int fails = 0;
  logic [31:0] rx_model = '0;

  logic        mon_rise = 1'b1;
  int          mon_cnt = 0;
  int          sclk_rises = 0;
  int          irq_wr_hi = 0;
  logic [31:0] mon_sh = '0;

  assign miso = loop_en ? mosi : 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_master u_spi_reg_master (
    .clk_i (clk), .rst_ni (rst_n), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .sclk_o (sclk), .miso_i (miso),
    .mosi_o (mosi), .cs_n_o (cs_n), .irq_o (irq)
  );

  always @(sclk) begin
    if (sclk === 1'b1) begin
      sclk_rises++;
      if (mon_rise) begin mon_sh = {mon_sh[30:0], mosi}; mon_cnt++; end
    end else if (sclk === 1'b0 && !mon_rise) begin
      mon_sh = {mon_sh[30:0], mosi}; mon_cnt++;
    end
  end

  always @(posedge clk) if (irq[1] === 1'b1) irq_wr_hi++;

  // stimulus vectors: {rise, div, len-1, read, tx}
  localparam logic [41:0] VECS [6] = '{
    {1'b1, 3'd0, 5'd7,  1'b1, 32'hA5C3_0000},
    {1'b0, 3'd1, 5'd15, 1'b1, 32'h1234_5678},
    {1'b1, 3'd2, 5'd31, 1'b1, 32'hDEAD_BEEF},
    {1'b0, 3'd0, 5'd3,  1'b1, 32'hC000_0000},
    {1'b1, 3'd0, 5'd12, 1'b0, 32'hFFF8_0000},
    {1'b0, 3'd3, 5'd31, 1'b0, 32'h8000_0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic run_vec(input logic rise, input logic [2:0] div, input logic [4:0] lenm1,
                         input logic rd, input logic [31:0] tx);
    int n, t, r0, m0;
    logic [15:0] v, lo, hi;
    logic [63:0] mask;
    n = (int'(lenm1) + 1 < 4) ? 4 : int'(lenm1) + 1;
    t = 2 * n * (1 << div);
    mask = (64'd1 << n) - 64'd1;
    bus_wr(3'd1, {15'd0, rise});
    bus_wr(3'd0, {12'd0, div, 1'b1});
    bus_wr(3'd4, tx[15:0]);
    bus_wr(3'd5, tx[31:16]);
    bus_wr(3'd3, 16'h0000);
    mon_rise = rise;
    r0 = sclk_rises; m0 = mon_cnt;
    bus_wr(3'd2, {9'd0, lenm1, ~rd, rd});
    repeat (t) @(posedge clk);
    @(negedge clk);
    bus_rd(3'd3, v);
    check("R3 flag early", {16'd0, v}, 32'd0);
    @(negedge clk);
    bus_rd(3'd3, v);
    check("R3/R9 flag due", {16'd0, v}, rd ? 32'd1 : 32'd2);
    check("R4 sclk rises", sclk_rises - r0, n);
    check("R5 bits seen", mon_cnt - m0, n);
    check("R5 mosi order", 32'(64'(mon_sh) & mask), tx >> (32 - n));
    if (rd) rx_model = tx >> (32 - n);
    bus_rd(3'd6, lo);
    bus_rd(3'd7, hi);
    check("R6 rx data", {hi, lo}, rx_model);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int r0, h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 cs_n", {30'd0, cs_n}, 32'd3);
    check("R2 sclk", {31'd0, sclk}, 32'd0);
    check("R2 irq", {30'd0, irq}, 32'd3);
    bus_rd(3'd3, v); check("R2 status", {16'd0, v}, 32'd0);
    bus_rd(3'd2, v); check("R2 ctrl", {16'd0, v}, 32'd0);
    bus_rd(3'd0, v); check("R2 setup A", {16'd0, v}, 32'd0);

    // R1 register readback
    bus_wr(3'd0, 16'hFFFF); bus_rd(3'd0, v); check("R1 setup A", {16'd0, v}, 32'h3F);
    bus_wr(3'd1, 16'hFFFF); bus_rd(3'd1, v); check("R1 setup B", {16'd0, v}, 32'h421);
    bus_wr(3'd5, 16'hBEEF); bus_rd(3'd5, v); check("R1 tx high", {16'd0, v}, 32'hBEEF);
    bus_wr(3'd0, 16'h0000); bus_wr(3'd1, 16'h0000);

    for (int i = 0; i < 6; i++)
      run_vec(VECS[i][41], VECS[i][40:38], VECS[i][37:33], VECS[i][32], VECS[i][31:0]);

    // R4 short length field clamps to four bits
    run_vec(1'b1, 3'd0, 5'd1, 1'b1, 32'h9000_0000);

    // R7 clock enable low holds the command
    bus_wr(3'd3, 16'h0000);
    bus_wr(3'd0, 16'h0000);
    r0 = sclk_rises;
    bus_wr(3'd2, 16'h001E);
    repeat (100) @(negedge clk);
    check("R7 no sclk", sclk_rises - r0, 0);
    bus_rd(3'd3, v); check("R7 no done", {16'd0, v}, 32'd0);
    bus_wr(3'd0, 16'h0001);
    repeat (30) @(negedge clk);
    bus_rd(3'd3, v); check("R7 resumes", {16'd0, v}, 32'd2);
    check("R7 rises", sclk_rises - r0, 8);

    // R8 command during busy is ignored
    bus_wr(3'd4, 16'h0F0F); bus_wr(3'd5, 16'h3C3C);
    bus_wr(3'd0, 16'h0005);
    bus_wr(3'd3, 16'h0000);
    r0 = sclk_rises;
    bus_wr(3'd2, 16'h007D);
    bus_wr(3'd2, 16'h000E);
    repeat (300) @(negedge clk);
    check("R8 rises", sclk_rises - r0, 32);
    bus_rd(3'd3, v); check("R8 flags", {16'd0, v}, 32'd1);
    bus_rd(3'd6, v); check("R8 rx low", {16'd0, v}, 32'h0F0F);

    // R9 start clears its own flag; status write clears zero bits
    bus_wr(3'd0, 16'h0001);
    bus_wr(3'd2, 16'h000D);
    bus_rd(3'd3, v); check("R9 start clears", {16'd0, v}, 32'd0);
    repeat (20) @(negedge clk);
    bus_wr(3'd2, 16'h000E);
    bus_rd(3'd3, v); check("R9 other kept", {16'd0, v}, 32'd1);
    repeat (20) @(negedge clk);
    bus_rd(3'd3, v); check("R9 both set", {16'd0, v}, 32'd3);
    bus_wr(3'd3, 16'h0002);
    bus_rd(3'd3, v); check("R9 clear read", {16'd0, v}, 32'd2);
    bus_wr(3'd3, 16'h0000);
    bus_rd(3'd3, v); check("R9 clear all", {16'd0, v}, 32'd0);

    // R10 chip select commands
    r0 = sclk_rises;
    bus_wr(3'd2, 16'h05FC); check("R10 assert both", {30'd0, cs_n}, 32'd0);
    bus_wr(3'd2, 16'h05FD); check("R10 release both", {30'd0, cs_n}, 32'd3);
    bus_wr(3'd2, 16'h0480); check("R10 line0", {30'd0, cs_n}, 32'd2);
    repeat (20) @(negedge clk);
    check("R10 no shift", sclk_rises - r0, 0);
    bus_rd(3'd3, v); check("R10 flags", {16'd0, v}, 32'd0);
    bus_wr(3'd2, 16'h0481); check("R10 release", {30'd0, cs_n}, 32'd3);

    // R11 level interrupts, active low then active high
    bus_wr(3'd0, 16'h0031);
    bus_wr(3'd1, 16'h0000);
    check("R11 idle neg", {30'd0, irq}, 32'd3);
    bus_wr(3'd2, 16'h000E);
    repeat (20) @(negedge clk);
    check("R11 wr active low", {30'd0, irq}, 32'd1);
    bus_wr(3'd3, 16'h0000);
    repeat (2) @(negedge clk);
    check("R11 cleared", {30'd0, irq}, 32'd3);
    bus_wr(3'd1, 16'h0020);
    check("R11 idle pos", {30'd0, irq}, 32'd0);
    bus_wr(3'd2, 16'h000D);
    repeat (20) @(negedge clk);
    check("R11 rd active high", {30'd0, irq}, 32'd1);
    bus_wr(3'd3, 16'h0000);
    bus_wr(3'd0, 16'h0001);
    bus_wr(3'd2, 16'h000E);
    repeat (20) @(negedge clk);
    check("R11 disabled", {30'd0, irq}, 32'd0);
    bus_wr(3'd3, 16'h0000);

    // R12 edge signalling gives one pulse
    bus_wr(3'd0, 16'h0011);
    bus_wr(3'd1, 16'h0420);
    h0 = irq_wr_hi;
    bus_wr(3'd2, 16'h000E);
    repeat (30) @(negedge clk);
    check("R12 pulse count", irq_wr_hi - h0, 1);
    check("R12 back idle", {31'd0, irq[1]}, 32'd0);
    bus_rd(3'd3, v); check("R12 flag held", {16'd0, v}, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule